// File: doc/BRIEF.md
# Two-Way Overlapped-Translation Load Cache

This block is a read-only data cache placed between a processor load port, a translation buffer lookup port, a page-walk request port and a main-memory read port. A load presents a 32-bit virtual byte address. The set index comes from address bits that are never translated, so the set contents are read in the same cycle that the upper 20 address bits go out to the translation buffer. The returned frame number is then compared with the physical tag held in each of the two ways.

Pages are 4 KB. The index is 10 bits wide and sits just above a 2-bit byte offset, so it stays inside the page displacement. Total capacity is 8 KB, held as two ways of 1024 one-word lines. A load resolves in one of four ways:

- The translation misses. A page walk is requested, and the set is compared again with the walked frame.
- The translation hits and a way hits. The word is delivered.
- The translation hits but no way hits. Memory is read at the translated address, and the word is written into the least recently used way.
- The load arrives while the block is busy. The CPU port is stalled and the request is not taken.

Top module: `vipt_cache`

## Requirements
- R1: After reset, `cpu_busy`, `cpu_rvalid`, `tlb_lookup`, `walk_req` and `mem_req` are all low.
- R2: A load is accepted on a clock edge where `cpu_req_valid` is high and `cpu_busy` is low. In the following cycle, `tlb_lookup` is high and `tlb_vpn` equals address bits [31:12]. Bits [1:0] do not affect the set or the tag, so addresses that differ only there return the same word.
- R3: If the translation hits and a valid way holds a tag equal to `tlb_ppn`, `cpu_rdata` carries that word with `cpu_rvalid` high. This happens in the cycle after the lookup cycle, and no memory read occurs.
- R4: If the translation hits and no way matches, one memory read is made. `mem_addr` is {frame[19:0], vaddr[11:2], 2'b00}, and it is held with `mem_req` until `mem_ack`. The word on `mem_rdata` at `mem_ack` is delivered on the next cycle.
- R5: A translation miss takes priority over any tag match. `walk_req` is raised with `walk_vpn`, and no data is delivered and no memory read is made until `walk_done`.
- R6: After `walk_done`, the set is compared against `walk_ppn`. On a match the word is delivered without a memory read. On a mismatch the refill of R4 follows, using that frame.
- R7: Two lines with different frames at the same set index are held at once, one in each way.
- R8: Each set has one replacement bit, cleared at reset, that names way 0 first. A refill writes the way that bit names. Any hit or refill then points the bit at the other way.
- R9: `cpu_busy` is high from the cycle after acceptance until the cycle in which `cpu_rvalid` is high. Requests presented while busy are dropped.
- R10: `cpu_rvalid` is a single-cycle pulse for each accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req_valid | input | 1 | Load request |
| cpu_vaddr | input | 32 | Virtual byte address of the load |
| cpu_busy | output | 1 | Stall: block cannot take a load |
| cpu_rvalid | output | 1 | Load data valid pulse |
| cpu_rdata | output | 32 | Load data |
| tlb_lookup | output | 1 | Translation lookup in progress |
| tlb_vpn | output | 20 | Virtual page number being translated |
| tlb_hit | input | 1 | Translation buffer hit, same cycle |
| tlb_ppn | input | 20 | Translated frame number, same cycle |
| walk_req | output | 1 | Full translation requested |
| walk_vpn | output | 20 | Page number to walk |
| walk_done | input | 1 | Walk finished pulse |
| walk_ppn | input | 20 | Frame number from the walk |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Physical word-aligned read address |
| mem_ack | input | 1 | Memory data valid pulse |
| mem_rdata | input | 32 | Memory read data |

## Verification
The set read and the translation happen in the same cycle, so a tag match can coincide with a translation miss. The bench's translation model drives the correct frame on `tlb_ppn` even when it reports a miss. It then reloads a page whose line is already cached. The load must still raise a walk, must not deliver data before `walk_done`, and must then hit without a memory read. Refill and replacement can also land on the same set in one cycle. Three frames that share one index are cycled, and every memory read is counted against the expected eviction order.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
    localparam int VA_W   = 32;
    localparam int PAGE_W = 12;
    localparam int OFF_W  = 2;
    localparam int IDX_W  = 10;
    localparam int DATA_W = 32;
    localparam int WAYS   = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WALK,
        ST_CHECK,
        ST_FILL
    } cstate_e;
endpackage

// File: rtl/vipt_way_store.sv
module vipt_way_store #(
    parameter int IDX_W  = vipt_pkg::IDX_W,
    parameter int TAG_W  = 20,
    parameter int DATA_W = vipt_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0]   valid_q, valid_d;
    logic [TAG_W-1:0]  tag_q  [SETS];
    logic [DATA_W-1:0] data_q [SETS];

    // The write always targets the set being looked up.
    always_comb begin
        valid_d = valid_q;
        if (wr_en) valid_d[rd_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[rd_idx]  <= wr_tag;
            data_q[rd_idx] <= wr_data;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx];

    // R7: a line is only written into a set that is fully addressed
    a_r7_write_known: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown(rd_idx));
endmodule

// File: rtl/vipt_lru.sv
module vipt_lru #(
    parameter int IDX_W = vipt_pkg::IDX_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    output logic             victim,
    input  logic             upd_en,
    input  logic             upd_way
);
    localparam int SETS = 1 << IDX_W;

    logic [SETS-1:0] lru_q, lru_d;

    always_comb begin
        lru_d = lru_q;
        if (upd_en) lru_d[idx] = ~upd_way;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lru_q <= '0;
        else        lru_q <= lru_d;
    end

    assign victim = lru_q[idx];

    // R8: after an update the set points away from the way just used
    a_r8_points_away: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en |=> (lru_q[$past(idx)] != $past(upd_way)));
endmodule

// File: rtl/vipt_ctrl.sv
module vipt_ctrl
    import vipt_pkg::*;
#(
    parameter int VA_W   = vipt_pkg::VA_W,
    parameter int PAGE_W = vipt_pkg::PAGE_W,
    parameter int OFF_W  = vipt_pkg::OFF_W,
    parameter int IDX_W  = vipt_pkg::IDX_W,
    parameter int DATA_W = vipt_pkg::DATA_W,
    parameter int NWAY   = vipt_pkg::WAYS,
    localparam int VPN_W = VA_W - PAGE_W,
    localparam int WA_W  = VA_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req_valid,
    input  logic [VA_W-1:0]              cpu_vaddr,
    output logic                         cpu_busy,
    output logic                         cpu_rvalid,
    output logic [DATA_W-1:0]            cpu_rdata,
    output logic                         tlb_lookup,
    output logic [VPN_W-1:0]             tlb_vpn,
    input  logic                         tlb_hit,
    input  logic [VPN_W-1:0]             tlb_ppn,
    output logic                         walk_req,
    output logic [VPN_W-1:0]             walk_vpn,
    input  logic                         walk_done,
    input  logic [VPN_W-1:0]             walk_ppn,
    output logic                         mem_req,
    output logic [VA_W-1:0]              mem_addr,
    input  logic                         mem_ack,
    input  logic [DATA_W-1:0]            mem_rdata,
    output logic [IDX_W-1:0]             set_idx,
    input  logic [NWAY-1:0]              way_valid,
    input  logic [NWAY-1:0][VPN_W-1:0]   way_tag,
    input  logic [NWAY-1:0][DATA_W-1:0]  way_data,
    input  logic                         victim,
    output logic [NWAY-1:0]              fill_en,
    output logic [VPN_W-1:0]             fill_tag,
    output logic [DATA_W-1:0]            fill_data,
    output logic                         lru_upd,
    output logic                         lru_way
);
    typedef struct packed {
        cstate_e           st;
        logic [WA_W-1:0]   waddr;
        logic [VPN_W-1:0]  ppn;
        logic              rvalid;
        logic [DATA_W-1:0] rdata;
    } ctrl_t;

    ctrl_t r_q, r_d;

    logic [NWAY-1:0]  way_hit;
    logic [VPN_W-1:0] cmp_ppn;
    logic             any_hit;
    logic             hit_way;

    assign set_idx = r_q.waddr[IDX_W-1:0];
    assign tlb_vpn = r_q.waddr[WA_W-1 -: VPN_W];
    assign cmp_ppn = (r_q.st == ST_CHECK) ? r_q.ppn : tlb_ppn;

    always_comb begin
        for (int w = 0; w < NWAY; w++) begin
            way_hit[w] = way_valid[w] && (way_tag[w] == cmp_ppn);
        end
    end
    assign any_hit = |way_hit;
    assign hit_way = way_hit[1];

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        tlb_lookup = 1'b0;
        walk_req   = 1'b0;
        mem_req    = 1'b0;
        fill_en    = '0;
        lru_upd    = 1'b0;
        lru_way    = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    r_d.waddr = cpu_vaddr[VA_W-1:OFF_W];
                    r_d.st    = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                tlb_lookup = 1'b1;
                if (!tlb_hit) begin
                    r_d.st = ST_WALK;
                end else if (any_hit) begin
                    r_d.rdata  = way_data[hit_way];
                    r_d.rvalid = 1'b1;
                    r_d.st     = ST_IDLE;
                    lru_upd    = 1'b1;
                    lru_way    = hit_way;
                end else begin
                    r_d.ppn = tlb_ppn;
                    r_d.st  = ST_FILL;
                end
            end
            ST_WALK: begin
                walk_req = 1'b1;
                if (walk_done) begin
                    r_d.ppn = walk_ppn;
                    r_d.st  = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (any_hit) begin
                    r_d.rdata  = way_data[hit_way];
                    r_d.rvalid = 1'b1;
                    r_d.st     = ST_IDLE;
                    lru_upd    = 1'b1;
                    lru_way    = hit_way;
                end else begin
                    r_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    fill_en[victim] = 1'b1;
                    r_d.rdata       = mem_rdata;
                    r_d.rvalid      = 1'b1;
                    r_d.st          = ST_IDLE;
                    lru_upd         = 1'b1;
                    lru_way         = victim;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st     <= ST_IDLE;
            r_q.waddr  <= '0;
            r_q.ppn    <= '0;
            r_q.rvalid <= 1'b0;
            r_q.rdata  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign walk_vpn  = tlb_vpn;
    assign mem_addr  = {r_q.ppn, set_idx, {OFF_W{1'b0}}};
    assign fill_tag  = r_q.ppn;
    assign fill_data = mem_rdata;
    assign cpu_busy  = (r_q.st != ST_IDLE);
    assign cpu_rvalid = r_q.rvalid;
    assign cpu_rdata  = r_q.rdata;

    // R3: at most one way can match the compared frame
    a_r3_single_way_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_LOOKUP || r_q.st == ST_CHECK) |-> $onehot0(way_hit));
    // R5: a translation miss never yields data next cycle and starts a walk
    a_r5_miss_walks: assert property (@(posedge clk) disable iff (!rst_n)
        (tlb_lookup && !tlb_hit) |=> (!cpu_rvalid && walk_req));
    // R5: no memory read while a walk is outstanding
    a_r5_walk_excludes_mem: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !mem_req);
    // R4: memory request and address held until acknowledged
    a_r4_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
    // R10: delivery is a one-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |=> !cpu_rvalid);
    // R9: the stall drops in the delivery cycle
    a_r9_busy_ends: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rvalid |-> !cpu_busy);
endmodule

// File: rtl/vipt_cache.sv
module vipt_cache
    import vipt_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cpu_req_valid,
    input  logic [31:0] cpu_vaddr,
    output logic        cpu_busy,
    output logic        cpu_rvalid,
    output logic [31:0] cpu_rdata,
    output logic        tlb_lookup,
    output logic [19:0] tlb_vpn,
    input  logic        tlb_hit,
    input  logic [19:0] tlb_ppn,
    output logic        walk_req,
    output logic [19:0] walk_vpn,
    input  logic        walk_done,
    input  logic [19:0] walk_ppn,
    output logic        mem_req,
    output logic [31:0] mem_addr,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata
);
    localparam int VPN_W = VA_W - PAGE_W;

    logic [IDX_W-1:0]                set_idx;
    logic [WAYS-1:0]                 way_valid;
    logic [WAYS-1:0][VPN_W-1:0]      way_tag;
    logic [WAYS-1:0][DATA_W-1:0]     way_data;
    logic [WAYS-1:0]                 fill_en;
    logic [VPN_W-1:0]                fill_tag;
    logic [DATA_W-1:0]               fill_data;
    logic                            victim;
    logic                            lru_upd;
    logic                            lru_way;

    vipt_ctrl #(
        .VA_W(VA_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W),
        .IDX_W(IDX_W), .DATA_W(DATA_W), .NWAY(WAYS)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_vaddr(cpu_vaddr),
        .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_done(walk_done), .walk_ppn(walk_ppn),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .set_idx(set_idx), .way_valid(way_valid),
        .way_tag(way_tag), .way_data(way_data),
        .victim(victim), .fill_en(fill_en),
        .fill_tag(fill_tag), .fill_data(fill_data),
        .lru_upd(lru_upd), .lru_way(lru_way)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        vipt_way_store #(
            .IDX_W(IDX_W), .TAG_W(VPN_W), .DATA_W(DATA_W)
        ) u_store (
            .clk(clk), .rst_n(rst_n),
            .rd_idx(set_idx),
            .rd_valid(way_valid[w]), .rd_tag(way_tag[w]), .rd_data(way_data[w]),
            .wr_en(fill_en[w]), .wr_tag(fill_tag), .wr_data(fill_data)
        );
    end

    vipt_lru #(.IDX_W(IDX_W)) u_lru (
        .clk(clk), .rst_n(rst_n),
        .idx(set_idx), .victim(victim),
        .upd_en(lru_upd), .upd_way(lru_way)
    );

    // R8: a refill writes exactly one way
    a_r8_one_way_filled: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(fill_en) <= 1);
endmodule

// File: tb/tb_vipt_cache.sv
module tb_vipt_cache;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] va;
        logic        fill;
        logic        walk;
    } vec_t;

    // Set index 5 shared by A, B, C, D; E uses set 6.
    // A=00012014 B=00045014 C=00078014 D=F00AB014 (translation miss page)
    localparam vec_t VEC [14] = '{
        '{32'h0001_2014, 1'b1, 1'b0},  // A fill way0
        '{32'h0001_2016, 1'b0, 1'b0},  // A, byte offset differs: hit
        '{32'h0004_5014, 1'b1, 1'b0},  // B fill way1
        '{32'h0001_2014, 1'b0, 1'b0},  // A hit
        '{32'h0007_8014, 1'b1, 1'b0},  // C evicts B
        '{32'h0001_2014, 1'b0, 1'b0},  // A hit
        '{32'h0004_5014, 1'b1, 1'b0},  // B evicts C
        '{32'h0007_8014, 1'b1, 1'b0},  // C evicts A
        '{32'h0001_2014, 1'b1, 1'b0},  // A evicts B
        '{32'h0007_8014, 1'b0, 1'b0},  // C hit
        '{32'h0001_2018, 1'b1, 1'b0},  // E other set
        '{32'hF00A_B014, 1'b1, 1'b1},  // D walk then fill
        '{32'hF00A_B014, 1'b0, 1'b1},  // D walk then hit
        '{32'h0001_2014, 1'b1, 1'b0}   // A evicted by D
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req_valid = 1'b0;
    logic [31:0] cpu_vaddr = '0;
    logic        cpu_busy, cpu_rvalid;
    logic [31:0] cpu_rdata;
    logic        tlb_lookup;
    logic [19:0] tlb_vpn;
    logic        tlb_hit;
    logic [19:0] tlb_ppn;
    logic        walk_req;
    logic [19:0] walk_vpn;
    logic        walk_done = 1'b0;
    logic [19:0] walk_ppn = '0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int errors = 0;
    int fills = 0;
    int walks = 0;
    int mcnt = 0;
    int wcnt = 0;
    logic [31:0] last_maddr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [19:0] xlate(input logic [19:0] v);
        return v ^ 20'h3C3C3;
    endfunction

    function automatic logic [31:0] memword(input logic [31:0] p);
        return {p[15:0], p[31:16]} ^ 32'hA5C3_0F96;
    endfunction

    function automatic logic [31:0] phys(input logic [31:0] va);
        return {xlate(va[31:12]), va[11:2], 2'b00};
    endfunction

    // Translation buffer model: pages with top nibble F miss, but the
    // correct frame is still driven on tlb_ppn.
    assign tlb_hit = (tlb_vpn[19:16] != 4'hF);
    assign tlb_ppn = xlate(tlb_vpn);

    dut_wrap: begin end

    vipt_cache dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_vaddr(cpu_vaddr),
        .cpu_busy(cpu_busy), .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata),
        .tlb_lookup(tlb_lookup), .tlb_vpn(tlb_vpn),
        .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn),
        .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_done(walk_done), .walk_ppn(walk_ppn),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    always @(posedge clk) begin
        mem_ack <= 1'b0;
        if (mem_req && mem_ack) begin
            fills <= fills + 1;
            last_maddr <= mem_addr;
        end
        if (mem_req && !mem_ack) begin
            if (mcnt == 1) begin
                mem_ack   <= 1'b1;
                mem_rdata <= memword(mem_addr);
                mcnt      <= 0;
            end else begin
                mcnt <= mcnt + 1;
            end
        end
    end

    always @(posedge clk) begin
        walk_done <= 1'b0;
        if (walk_req && walk_done) walks <= walks + 1;
        if (walk_req && !walk_done) begin
            if (wcnt == 2) begin
                walk_done <= 1'b1;
                walk_ppn  <= xlate(walk_vpn);
                wcnt      <= 0;
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [31:0] va, output logic [31:0] data,
                           output int lat);
        @(negedge clk);
        cpu_vaddr     = va;
        cpu_req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        // R2: lookup cycle presents the page number
        chk(tlb_lookup === 1'b1, "R2 lookup", {31'd0, tlb_lookup}, 32'd1);
        chk(tlb_vpn === va[31:12], "R2 vpn", {12'd0, tlb_vpn}, {12'd0, va[31:12]});
        chk(cpu_busy === 1'b1, "R9 busy", {31'd0, cpu_busy}, 32'd1);
        lat = 0;
        while (cpu_rvalid !== 1'b1) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        data = cpu_rdata;
        chk(cpu_busy === 1'b0, "R9 release", {31'd0, cpu_busy}, 32'd0);
        @(negedge clk);
        chk(cpu_rvalid === 1'b0, "R10 pulse", {31'd0, cpu_rvalid}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] data;
        int lat;
        int f0, w0;

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cpu_busy === 1'b0, "R1 busy", {31'd0, cpu_busy}, 32'd0);
        chk(cpu_rvalid === 1'b0, "R1 rvalid", {31'd0, cpu_rvalid}, 32'd0);
        chk(mem_req === 1'b0, "R1 mem_req", {31'd0, mem_req}, 32'd0);
        chk(walk_req === 1'b0, "R1 walk_req", {31'd0, walk_req}, 32'd0);
        chk(tlb_lookup === 1'b0, "R1 lookup", {31'd0, tlb_lookup}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        for (int i = 0; i < 14; i++) begin
            f0 = fills;
            w0 = walks;
            do_load(VEC[i].va, data, lat);
            // R3 R4 R6: delivered word is the memory word at the physical address
            chk(data === memword(phys(VEC[i].va)), "R3/R4/R6 data", data,
                memword(phys(VEC[i].va)));
            // R7 R8: refill count follows the two-way replacement order
            chk((fills - f0) == int'(VEC[i].fill), "R7/R8 fill count",
                fills - f0, {31'd0, VEC[i].fill});
            // R5: walks only for translation misses
            chk((walks - w0) == int'(VEC[i].walk), "R5 walk count",
                walks - w0, {31'd0, VEC[i].walk});
            if (VEC[i].fill)
                chk(last_maddr === phys(VEC[i].va), "R4 mem_addr", last_maddr,
                    phys(VEC[i].va));
            if (!VEC[i].fill && !VEC[i].walk)
                chk(lat == 1, "R3 hit latency", lat, 32'd1);
        end

        // R5: cached page with a translation miss gives no data before the walk ends
        @(negedge clk);
        cpu_vaddr     = 32'hF00A_B014;
        cpu_req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(cpu_rvalid === 1'b0, "R5 no early data", {31'd0, cpu_rvalid}, 32'd0);
        chk(walk_req === 1'b1, "R5 walk raised", {31'd0, walk_req}, 32'd1);
        chk(walk_vpn === 20'hF00AB, "R5 walk_vpn", {12'd0, walk_vpn}, 32'h000F00AB);
        chk(mem_req === 1'b0, "R5 no mem", {31'd0, mem_req}, 32'd0);
        while (cpu_rvalid !== 1'b1) @(negedge clk);
        chk(cpu_rdata === memword(phys(32'hF00A_B014)), "R6 data after walk",
            cpu_rdata, memword(phys(32'hF00A_B014)));

        // R9: requests presented while busy are dropped
        repeat (2) @(negedge clk);
        f0 = fills;
        cpu_vaddr     = 32'h0009_9020;
        cpu_req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cpu_vaddr = 32'h0001_2014;
        repeat (2) @(negedge clk);
        cpu_req_valid = 1'b0;
        while (cpu_rvalid !== 1'b1) @(negedge clk);
        chk(cpu_rdata === memword(phys(32'h0009_9020)), "R9 first load kept",
            cpu_rdata, memword(phys(32'h0009_9020)));
        repeat (3) begin
            @(negedge clk);
            chk(cpu_busy === 1'b0 && cpu_rvalid === 1'b0, "R9 dropped request",
                {30'd0, cpu_busy, cpu_rvalid}, 32'd0);
        end
        chk(fills - f0 == 1, "R9 single refill", fills - f0, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule